// File: doc/BRIEF.md
# Programmable baud clock divider

This block divides an input oscillator of roughly 1.85 MHz down to the 16x sampling clock that a serial port needs. Software loads a 16-bit divisor through a byte-wide register port. Writes and reads reach the divisor bytes only while the divisor access bit `dlab_i` is set. Any write to a divisor byte restarts the division period at once, so the new rate starts on the next oscillator cycle and not at the end of an old long count.

Divisors 0, 1 and 2 each give their own waveform. Any divisor of 3 or more gives a period of that many oscillator cycles, and the output is low for the first two cycles of each period. When the high-speed enable `hs_en_i` is set, two divisor codes with bit 15 set take their clock from a 4x reference input and give twice or four times the divisor-1 rate. The divide-by-1 and 4x outputs are inverted clocks passed through the output mux. Every other mode drives the output from a flip-flop.

Top module: `baud_clk_div`

## Requirements
- R1: After reset the divisor reads 0 in both bytes and `baud16_o` stays high until the first accepted divisor write.
- R2: With `dlab_i`=1, `addr_i`=0 selects the low divisor byte and `addr_i`=1 selects the high byte, for both write and read. With `dlab_i`=0, writes are ignored and `rdata_o` reads 0.
- R3: A divisor write restarts the period. In registered modes `baud16_o` is low in the oscillator cycle right after the writing edge, and the new period counts from that edge.
- R4: Divisor 0 gives a period of 3 cycles: low for 1 cycle, then high for 2.
- R5: Divisor 1 drives `baud16_o` with the inverse of `clk_i`.
- R6: Divisor 2 makes `baud16_o` change level on every `clk_i` rising edge. The first cycle after a write is low.
- R7: A divisor N of 3 or more gives a period of N cycles: low for 2 cycles, then high for N-2.
- R8: With `hs_en_i`=0, bit 15 is an ordinary divisor bit. Divisor 0x8001 gives a period of 32769 cycles under the rule of R7.
- R9: With `hs_en_i`=1 and divisor 0x8002, `baud16_o` changes level on each rising edge of `clk4x_i`. This is twice the `clk_i` rate.
- R10: With `hs_en_i`=1 and divisor 0x8001, `baud16_o` is the inverse of `clk4x_i`. This is four times the `clk_i` rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input oscillator |
| clk4x_i | input | 1 | Reference clock at four times the oscillator rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dlab_i | input | 1 | Divisor access enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Byte select: 0 low, 1 high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| hs_en_i | input | 1 | High-speed code enable |
| baud16_o | output | 1 | 16x baud clock |

## Verification
A wrong count or phase register shows up at `baud16_o` as a low pulse in the wrong cycle. For short divisors this is visible within one period, and the bench finds it because it compares against its own model on every oscillator cycle. A corrupted divisor latch shows up on the next read through `rdata_o`, and also as a wrong period from the cycle after the write. A wrong selection of the high-speed path or the inverted-clock path changes the number of output edges, which the bench counts over a 40 ns window.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_INV = 2'd1,
    SRC_HS2 = 2'd2,
    SRC_HS4 = 2'd3
  } src_e;

  localparam int unsigned LONG_LOW = 2;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dlab_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              load_o,
  output logic              armed_o
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              armed_q;

  assign load_o = we_i & dlab_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      armed_q <= 1'b0;
    end else if (load_o) begin
      armed_q <= 1'b1;
      if (addr_i) hi_q <= wdata_i;
      else        lo_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (dlab_i) rdata_o = addr_i ? hi_q : lo_q;
  end

  assign div_o   = {hi_q, lo_q};
  assign armed_o = armed_q;
endmodule

// File: rtl/baud_div_core.sv
module baud_div_core
  import baud_div_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_next_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             out_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] per_now, per_new, low_now, low_new;
  logic [DIV_W-1:0] per_sel, low_sel;
  logic             out_q;

  function automatic logic [DIV_W-1:0] period_of(logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(3) : d;
  endfunction

  function automatic logic [DIV_W-1:0] lowlen_of(logic [DIV_W-1:0] d);
    return (d < DIV_W'(3)) ? DIV_W'(1) : DIV_W'(LONG_LOW);
  endfunction

  assign per_now = period_of(div_i);
  assign low_now = lowlen_of(div_i);
  assign per_new = period_of(div_next_i);
  assign low_new = lowlen_of(div_next_i);

  always_comb begin
    per_sel = per_now;
    low_sel = low_now;
    cnt_d   = cnt_q;
    if (load_i) begin
      per_sel = per_new;
      low_sel = low_new;
      cnt_d   = per_new - DIV_W'(1);
    end else if (armed_i) begin
      cnt_d = (cnt_q == '0) ? per_now - DIV_W'(1) : cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (load_i || armed_i) begin
      cnt_q <= cnt_d;
      out_q <= (cnt_d < per_sel - low_sel);
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/baud_div_hs.sv
module baud_div_hs (
  input  logic clk4x_i,
  input  logic rst_ni,
  output logic hs2_o,
  output logic hs4_o
);
  logic tog_q;

  always_ff @(posedge clk4x_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b1;
    else         tog_q <= ~tog_q;
  end

  assign hs2_o = tog_q;
  assign hs4_o = ~clk4x_i;
endmodule

// File: rtl/baud_clk_div.sv
module baud_clk_div
  import baud_div_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned HS2_LOW = 2,
  parameter int unsigned HS4_LOW = 1,
  localparam int unsigned DIV_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              clk4x_i,
  input  logic              rst_ni,
  input  logic              dlab_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              hs_en_i,
  output logic              baud16_o
);
  localparam logic [DIV_W-1:0] HS2_CODE = {1'b1, (DIV_W-1)'(HS2_LOW)};
  localparam logic [DIV_W-1:0] HS4_CODE = {1'b1, (DIV_W-1)'(HS4_LOW)};

  logic [DIV_W-1:0] div_q, div_next;
  logic             load, armed, reg_out, hs2, hs4;
  src_e             src;

  baud_div_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dlab_i  (dlab_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .div_o   (div_q),
    .load_o  (load),
    .armed_o (armed)
  );

  assign div_next = addr_i ? {wdata_i, div_q[BYTE_W-1:0]}
                           : {div_q[DIV_W-1:BYTE_W], wdata_i};

  baud_div_core #(.DIV_W(DIV_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .armed_i    (armed),
    .load_i     (load),
    .div_next_i (div_next),
    .div_i      (div_q),
    .out_o      (reg_out)
  );

  baud_div_hs u_hs (
    .clk4x_i (clk4x_i),
    .rst_ni  (rst_ni),
    .hs2_o   (hs2),
    .hs4_o   (hs4)
  );

  always_comb begin
    src = SRC_REG;
    if (hs_en_i && div_q == HS2_CODE)      src = SRC_HS2;
    else if (hs_en_i && div_q == HS4_CODE) src = SRC_HS4;
    else if (div_q == DIV_W'(1))           src = SRC_INV;
  end

  always_comb begin
    unique case (src)
      SRC_INV: baud16_o = ~clk_i;
      SRC_HS2: baud16_o = hs2;
      SRC_HS4: baud16_o = hs4;
      default: baud16_o = reg_out;
    endcase
  end
endmodule

module baud_clk_div_chk #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dlab_i,
  input logic              we_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic [DIV_W-1:0]  div_q,
  input logic              reg_out,
  input logic              armed,
  input logic              baud16_o
);
  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> baud16_o);
  // R2
  dlab_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !dlab_i) |=> $stable(div_q));
  // R2
  rdata_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dlab_i |-> (rdata_o == '0));
  // R3
  reload_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dlab_i) |=> !reg_out);
  // R6
  div2_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == DIV_W'(2) && !(we_i && dlab_i)) |=> (reg_out != $past(reg_out)));
  // R7
  low_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q >= DIV_W'(3) && $fell(reg_out)) |=> !reg_out);
endmodule

bind baud_clk_div baud_clk_div_chk #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .dlab_i   (dlab_i),
  .we_i     (we_i),
  .rdata_o  (rdata_o),
  .div_q    (div_q),
  .reg_out  (reg_out),
  .armed    (armed),
  .baud16_o (baud16_o)
);

// File: tb/tb_baud_clk_div.sv
`timescale 1ns/1ps
module tb_baud_clk_div;
  logic       clk_i = 1'b0, clk4x_i = 1'b0, rst_ni = 1'b0;
  logic       dlab_i = 1'b0, we_i = 1'b0, addr_i = 1'b0, hs_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       baud16_o;

  int checks = 0, fails = 0, edges = 0;
  int m_div = 0, m_ph = 0;
  bit m_armed = 0, m_wr = 0, done = 0;

  always #2 clk_i = ~clk_i;
  always #0.5 clk4x_i = ~clk4x_i;

  baud_clk_div dut (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int per_f(int d);
    return d == 0 ? 3 : d;
  endfunction
  function automatic int low_f(int d);
    return d < 3 ? 1 : 2;
  endfunction

  // reference model: phase within period
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div = 0; m_ph = 0; m_armed = 0; m_wr = 0;
    end else if (we_i && dlab_i) begin
      if (addr_i) m_div = (m_div & 'h00ff) | (int'(wdata_i) << 8);
      else        m_div = (m_div & 'hff00) | int'(wdata_i);
      m_ph = 0; m_armed = 1; m_wr = 1;
    end else begin
      m_wr = 0;
      if (m_armed) m_ph = (m_ph + 1) % per_f(m_div);
    end
  end

  always @(negedge clk_i) begin
    bit skip, exp;
    string tag;
    skip = (m_div == 1) || (hs_en_i && (m_div == 'h8001 || m_div == 'h8002));
    if (rst_ni && !skip) begin
      exp = m_armed ? (m_ph >= low_f(m_div)) : 1'b1;
      if (!m_armed)                         tag = "R1";
      else if (m_wr)                        tag = "R3";
      else if (m_div == 0)                  tag = "R4";
      else if (m_div == 2)                  tag = "R6";
      else if (m_div >= 'h8000 && !hs_en_i) tag = "R8";
      else                                  tag = "R7";
      chk(baud16_o == exp, tag, baud16_o, exp);
    end
  end

  always @(posedge baud16_o) edges++;

  task automatic wr(bit dl, bit a, logic [7:0] d);
    @(posedge clk_i); #1;
    dlab_i = dl; addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #1;
    we_i = 1'b0; dlab_i = 1'b0;
  endtask

  task automatic rd(bit dl, bit a, logic [7:0] exp, string tag);
    @(posedge clk_i); #1;
    dlab_i = dl; addr_i = a;
    #0.5;
    chk(rdata_o == exp, tag, rdata_o, exp);
    dlab_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic count_edges(int exp, string tag);
    @(posedge clk_i); #1.25;
    edges = 0;
    #40;
    chk(edges == exp, tag, edges, exp);
  endtask

  initial begin
    #20000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1'b1;
    idle(3);
    rd(1, 0, 8'h00, "R1");
    rd(1, 1, 8'h00, "R1");
    idle(5);
    wr(1, 0, 8'd5);   idle(30);   // R7 N=5
    rd(1, 0, 8'd5, "R2");
    rd(1, 1, 8'd0, "R2");
    wr(0, 0, 8'd9);   idle(12);   // R2 ignored write
    rd(1, 0, 8'd5, "R2");
    rd(0, 0, 8'd0, "R2");
    wr(1, 0, 8'd0);   idle(30);   // R4
    wr(1, 0, 8'd2);   idle(20);   // R6
    wr(1, 0, 8'd3);   idle(20);   // R7 N=3
    wr(1, 0, 8'd12);  idle(5);
    wr(1, 0, 8'd12);  idle(40);   // R3 mid-period restart
    wr(1, 0, 8'd1);
    count_edges(10, "R5");
    wr(1, 1, 8'h80);
    wr(1, 0, 8'h01);  idle(33000); // R8 full long period
    rd(1, 1, 8'h80, "R2");
    @(posedge clk_i); #1 hs_en_i = 1'b1;
    count_edges(40, "R10");
    wr(1, 0, 8'h02);
    count_edges(20, "R9");
    @(posedge clk_i); #1 hs_en_i = 1'b0;
    idle(100);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule